// File: doc/BRIEF.md
# Address Translation Fault Sequencer

This block orders the translation of one memory access at a time. When the relocation enable for the access type is off, the virtual address is passed straight back with read-write permission. Otherwise the sequencer first asks an external block-range matcher for a result. Only when that matcher reports no hit does it ask an external page-table walker. A usable result from either block ends the request.

When no usable translation is found, the request ends with "no access". If the request carries the no-exception flag, nothing else happens. Otherwise the sequencer raises a fault. Two fault styles are available, chosen by `cfg_swreload`. The software-reload style writes a miss register, sets the temporary-GPR bit in the machine state and issues a reload vector. The storage-interrupt style writes the fault address and fault status registers and issues an instruction-storage or data-storage vector.

The states are IDLE, BAT, WALK, FAULT and DONE. The transitions are:

- **IDLE→DONE:** bypass.
- **IDLE→BAT:** relocation is on.
- **BAT→DONE:** usable block hit.
- **BAT→FAULT:** block hit with denied access.
- **BAT→WALK:** no block hit.
- **WALK→DONE:** usable table entry.
- **WALK→FAULT:** no entry, or an entry with access level zero.
- **FAULT→DONE:** always.
- **DONE→IDLE:** always.

The access codes are 0 (none), 1 (read-only) and 2 (read-write).

Top module: `xlat_fault_seq`

## Requirements
- R1: After reset the sequencer is in the following state: busy low, done low, no lookup requested, no exception requested.
- R2: A fetch with `cfg_ireloc`=0, or a data access with `cfg_dreloc`=0, completes with res_paddr equal to the virtual address and res_access=2, and issues no block or table lookup. The relocation enable that belongs to the other access type has no effect on this decision.
- R3: A block hit with access 1 or 2 completes with the block's physical address and access, and no table lookup is issued.
- R4: With no block hit, a table lookup is issued. A table entry found with nonzero access completes with the table's physical address and access.
- R5: A failure on a request with req_noexc=1 completes with res_access=0 and pulses none of the following: exc_req, the miss, address or status write enables, or msr_tgpr_set.
- R6: In software-reload style (`cfg_swreload`=1), a failure writes fault_addr=vaddr through imiss_we (fetch) or dmiss_we (data). It also pulses msr_tgpr_set. The vector is 0x10 for a fetch, 0x11 for a load and 0x12 for a store.
- R7: In storage-interrupt style, a data failure pulses dar_we with fault_addr=vaddr and pulses stat_we. In stat_bits, bit0 means no entry found, bit1 means an entry was found but was not usable (protection), and bit2 means the access was a store. The vector is VEC_DSI (default 0x03).
- R8: In storage-interrupt style, a fetch failure issues VEC_ISI (default 0x04) and writes neither the address nor the status register.
- R9: A block hit with access 0 is a fault even when a table entry exists. It issues no table lookup and is always reported in storage-interrupt style with the protection bit set.
- R10: done is high for exactly one cycle per request, and any exception pulse comes in the cycle before it. req_valid is ignored while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Start a request (accepted in IDLE only) |
| req_vaddr | input | AW | Virtual address |
| req_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| req_write | input | 1 | 1 = store |
| req_noexc | input | 1 | Fail silently, without side effects |
| cfg_ireloc | input | 1 | Instruction relocation enable |
| cfg_dreloc | input | 1 | Data relocation enable |
| cfg_swreload | input | 1 | 1 = software-reload fault style |
| busy | output | 1 | Request in progress |
| lk_vaddr | output | AW | Address presented to both lookup blocks |
| lk_fetch | output | 1 | Access type presented to the lookups |
| lk_write | output | 1 | Store flag presented to the lookups |
| bat_lookup | output | 1 | Block matcher request, held until answered |
| bat_resp_valid | input | 1 | Block matcher answer valid |
| bat_hit | input | 1 | Block range matched |
| bat_access | input | 2 | Block access code |
| bat_paddr | input | AW | Block physical address |
| walk_lookup | output | 1 | Table walker request, held until answered |
| walk_resp_valid | input | 1 | Walker answer valid |
| walk_found | input | 1 | Table entry found |
| walk_access | input | 2 | Table access code |
| walk_paddr | input | AW | Table physical address |
| done | output | 1 | Result valid (one cycle) |
| res_access | output | 2 | Result access code |
| res_paddr | output | AW | Result physical address |
| fault_addr | output | AW | Data for miss and fault-address registers |
| imiss_we | output | 1 | Instruction-miss register write |
| dmiss_we | output | 1 | Data-miss register write |
| dar_we | output | 1 | Fault-address register write |
| stat_we | output | 1 | Fault-status register write |
| stat_bits | output | 3 | Fault-status value |
| msr_tgpr_set | output | 1 | Set the temporary-GPR machine state bit |
| exc_req | output | 1 | Exception request |
| exc_vector | output | 8 | Exception vector number |

## Verification
Bypass is tried with each relocation enable off while the other is on. This shows that the right enable is chosen for the access type and that no lookup leaks out. Translation is tried with a usable block hit against a table answer that is ready and different, which shows that the fixed ordering is kept. It is also tried with a block miss that falls through to the table. Failures are driven as fetch, load and store under each style, with and without a found entry, with a denied block hit and with the silent flag. Together these separate the vectors, the status bit combinations and the absence of side effects. A second request held on req_valid during a busy request shows that input is ignored.

// File: rtl/xlat_seq_pkg.sv
package xlat_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BAT,
        ST_WALK,
        ST_FAULT,
        ST_DONE
    } seq_state_t;

    localparam logic [1:0] ACC_NONE = 2'd0;
    localparam logic [1:0] ACC_RW   = 2'd2;

    localparam int STB_NOTFOUND = 0;
    localparam int STB_PROT     = 1;
    localparam int STB_STORE    = 2;
    localparam int STAT_W       = 3;

    localparam logic [7:0] VEC_RLD_FETCH = 8'h10;
    localparam logic [7:0] VEC_RLD_LOAD  = 8'h11;
    localparam logic [7:0] VEC_RLD_STORE = 8'h12;
endpackage

// File: rtl/xlat_fault_encode.sv
module xlat_fault_encode
    import xlat_seq_pkg::*;
#(
    parameter logic [7:0] VEC_ISI = 8'h04,
    parameter logic [7:0] VEC_DSI = 8'h03
) (
    input  logic              en,
    input  logic              sw_style,
    input  logic              is_fetch,
    input  logic              is_write,
    input  logic              blk_denied,
    input  logic              entry_found,
    output logic              imiss_we,
    output logic              dmiss_we,
    output logic              dar_we,
    output logic              stat_we,
    output logic [STAT_W-1:0] stat_bits,
    output logic              tgpr_set,
    output logic              exc_req,
    output logic [7:0]        exc_vector
);
    logic use_reload;
    logic prot;

    // A denied block hit always takes the storage-interrupt path.
    assign use_reload = sw_style && !blk_denied;
    assign prot       = entry_found || blk_denied;

    always_comb begin
        imiss_we   = 1'b0;
        dmiss_we   = 1'b0;
        dar_we     = 1'b0;
        stat_we    = 1'b0;
        stat_bits  = '0;
        tgpr_set   = 1'b0;
        exc_req    = 1'b0;
        exc_vector = 8'h00;
        if (en) begin
            exc_req = 1'b1;
            if (use_reload) begin
                tgpr_set   = 1'b1;
                imiss_we   = is_fetch;
                dmiss_we   = !is_fetch;
                exc_vector = is_fetch ? VEC_RLD_FETCH :
                             (is_write ? VEC_RLD_STORE : VEC_RLD_LOAD);
            end else begin
                exc_vector = is_fetch ? VEC_ISI : VEC_DSI;
                if (!is_fetch) begin
                    dar_we                 = 1'b1;
                    stat_we                = 1'b1;
                    stat_bits[STB_PROT]     = prot;
                    stat_bits[STB_NOTFOUND] = !prot;
                    stat_bits[STB_STORE]    = is_write;
                end
            end
        end
    end
endmodule

// File: rtl/xlat_fault_seq.sv
module xlat_fault_seq
    import xlat_seq_pkg::*;
#(
    parameter int         AW      = 32,
    parameter logic [7:0] VEC_ISI = 8'h04,
    parameter logic [7:0] VEC_DSI = 8'h03
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [AW-1:0]     req_vaddr,
    input  logic              req_fetch,
    input  logic              req_write,
    input  logic              req_noexc,
    input  logic              cfg_ireloc,
    input  logic              cfg_dreloc,
    input  logic              cfg_swreload,
    output logic              busy,
    output logic [AW-1:0]     lk_vaddr,
    output logic              lk_fetch,
    output logic              lk_write,
    output logic              bat_lookup,
    input  logic              bat_resp_valid,
    input  logic              bat_hit,
    input  logic [1:0]        bat_access,
    input  logic [AW-1:0]     bat_paddr,
    output logic              walk_lookup,
    input  logic              walk_resp_valid,
    input  logic              walk_found,
    input  logic [1:0]        walk_access,
    input  logic [AW-1:0]     walk_paddr,
    output logic              done,
    output logic [1:0]        res_access,
    output logic [AW-1:0]     res_paddr,
    output logic [AW-1:0]     fault_addr,
    output logic              imiss_we,
    output logic              dmiss_we,
    output logic              dar_we,
    output logic              stat_we,
    output logic [STAT_W-1:0] stat_bits,
    output logic              msr_tgpr_set,
    output logic              exc_req,
    output logic [7:0]        exc_vector
);
    seq_state_t state_q, state_d;

    logic [AW-1:0] vaddr_q, pa_q;
    logic [1:0]    acc_q;
    logic          fetch_q, write_q, noexc_q, denied_q, found_q;
    logic          reloc_on;

    assign reloc_on = req_fetch ? cfg_ireloc : cfg_dreloc;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid) state_d = reloc_on ? ST_BAT : ST_DONE;
            ST_BAT:   if (bat_resp_valid) begin
                          if (!bat_hit)                 state_d = ST_WALK;
                          else if (bat_access != ACC_NONE) state_d = ST_DONE;
                          else                          state_d = ST_FAULT;
                      end
            ST_WALK:  if (walk_resp_valid)
                          state_d = (walk_found && walk_access != ACC_NONE) ? ST_DONE : ST_FAULT;
            ST_FAULT: state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Request and result holding registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vaddr_q  <= '0;
            pa_q     <= '0;
            acc_q    <= ACC_NONE;
            fetch_q  <= 1'b0;
            write_q  <= 1'b0;
            noexc_q  <= 1'b0;
            denied_q <= 1'b0;
            found_q  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (req_valid) begin
                    vaddr_q  <= req_vaddr;
                    fetch_q  <= req_fetch;
                    write_q  <= req_write;
                    noexc_q  <= req_noexc;
                    denied_q <= 1'b0;
                    found_q  <= 1'b0;
                    pa_q     <= req_vaddr;
                    acc_q    <= reloc_on ? ACC_NONE : ACC_RW;
                end
                ST_BAT: if (bat_resp_valid && bat_hit) begin
                    if (bat_access != ACC_NONE) begin
                        pa_q  <= bat_paddr;
                        acc_q <= bat_access;
                    end else begin
                        denied_q <= 1'b1;
                    end
                end
                ST_WALK: if (walk_resp_valid) begin
                    found_q <= walk_found;
                    if (walk_found && walk_access != ACC_NONE) begin
                        pa_q  <= walk_paddr;
                        acc_q <= walk_access;
                    end
                end
                ST_FAULT: acc_q <= ACC_NONE;
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        busy        = (state_q != ST_IDLE);
        bat_lookup  = (state_q == ST_BAT);
        walk_lookup = (state_q == ST_WALK);
        done        = (state_q == ST_DONE);
        lk_vaddr    = vaddr_q;
        lk_fetch    = fetch_q;
        lk_write    = write_q;
        res_access  = done ? acc_q : ACC_NONE;
        res_paddr   = done ? pa_q : '0;
        fault_addr  = vaddr_q;
    end

    xlat_fault_encode #(
        .VEC_ISI (VEC_ISI),
        .VEC_DSI (VEC_DSI)
    ) u_enc (
        .en          ((state_q == ST_FAULT) && !noexc_q),
        .sw_style    (cfg_swreload),
        .is_fetch    (fetch_q),
        .is_write    (write_q),
        .blk_denied  (denied_q),
        .entry_found (found_q),
        .imiss_we    (imiss_we),
        .dmiss_we    (dmiss_we),
        .dar_we      (dar_we),
        .stat_we     (stat_we),
        .stat_bits   (stat_bits),
        .tgpr_set    (msr_tgpr_set),
        .exc_req     (exc_req),
        .exc_vector  (exc_vector)
    );

    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R10
    exc_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req |=> done);
    // R3
    bat_hit_no_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bat_lookup && bat_resp_valid && bat_hit) |=> !walk_lookup);
    // R6
    miss_with_tgpr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (imiss_we || dmiss_we) |-> (msr_tgpr_set && exc_req));
    // R7
    dar_with_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dar_we |-> (stat_we && !msr_tgpr_set && $onehot0(stat_bits[1:0])));
    // R2
    bypass_no_lookup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid && !(req_fetch ? cfg_ireloc : cfg_dreloc)) |=> (done && !bat_lookup));
endmodule

// File: tb/xlat_fault_seq_bench.sv
module xlat_fault_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_fetch = 1'b0, req_write = 1'b0, req_noexc = 1'b0;
    logic [AW-1:0] req_vaddr = '0;
    logic cfg_ireloc = 1'b1, cfg_dreloc = 1'b1, cfg_swreload = 1'b0;
    logic busy, bat_lookup, walk_lookup, done, lk_fetch, lk_write;
    logic [AW-1:0] lk_vaddr, res_paddr, fault_addr;
    logic bat_resp_valid = 1'b0, bat_hit = 1'b0;
    logic [1:0] bat_access = 2'd0, walk_access = 2'd0, res_access;
    logic [AW-1:0] bat_paddr = '0, walk_paddr = '0;
    logic walk_resp_valid = 1'b0, walk_found = 1'b0;
    logic imiss_we, dmiss_we, dar_we, stat_we, msr_tgpr_set, exc_req;
    logic [2:0] stat_bits;
    logic [7:0] exc_vector;

    int tests = 0, fails = 0;

    // captured observations of one request
    logic s_done, s_bat, s_walk, s_exc, s_imiss, s_dmiss, s_dar, s_stat, s_tgpr, s_after_done;
    logic [1:0] s_acc;
    logic [AW-1:0] s_pa, s_faddr;
    logic [2:0] s_statv;
    logic [7:0] s_vec;

    always #(CLK_PERIOD/2) clk = ~clk;

    xlat_fault_seq u_xlat_fault_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_fetch(req_fetch), .req_write(req_write), .req_noexc(req_noexc),
        .cfg_ireloc(cfg_ireloc), .cfg_dreloc(cfg_dreloc), .cfg_swreload(cfg_swreload),
        .busy(busy), .lk_vaddr(lk_vaddr), .lk_fetch(lk_fetch), .lk_write(lk_write),
        .bat_lookup(bat_lookup), .bat_resp_valid(bat_resp_valid), .bat_hit(bat_hit),
        .bat_access(bat_access), .bat_paddr(bat_paddr),
        .walk_lookup(walk_lookup), .walk_resp_valid(walk_resp_valid),
        .walk_found(walk_found), .walk_access(walk_access), .walk_paddr(walk_paddr),
        .done(done), .res_access(res_access), .res_paddr(res_paddr),
        .fault_addr(fault_addr), .imiss_we(imiss_we), .dmiss_we(dmiss_we),
        .dar_we(dar_we), .stat_we(stat_we), .stat_bits(stat_bits),
        .msr_tgpr_set(msr_tgpr_set), .exc_req(exc_req), .exc_vector(exc_vector)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Issue one request and answer the lookups; hold_other keeps req_valid high with
    // another address for a few cycles while busy.
    task automatic run_req(input logic f, input logic w, input logic nx, input logic [AW-1:0] va,
                           input logic bh, input logic [1:0] ba, input logic [AW-1:0] bp,
                           input logic wf, input logic [1:0] wa, input logic [AW-1:0] wp,
                           input logic hold_other);
        s_done = 0; s_bat = 0; s_walk = 0; s_exc = 0; s_imiss = 0; s_dmiss = 0;
        s_dar = 0; s_stat = 0; s_tgpr = 0; s_acc = 0; s_pa = 0; s_faddr = 0;
        s_statv = 0; s_vec = 0; s_after_done = 0;
        bat_hit = bh; bat_access = ba; bat_paddr = bp;
        walk_found = wf; walk_access = wa; walk_paddr = wp;
        @(negedge clk);
        req_fetch = f; req_write = w; req_noexc = nx; req_vaddr = va; req_valid = 1'b1;
        @(negedge clk);
        if (hold_other) begin
            req_vaddr = va ^ 32'h0F0F_0000; req_fetch = ~f;
        end else begin
            req_valid = 1'b0;
        end
        for (int i = 0; i < 40; i++) begin
            if (hold_other && i == 3) req_valid = 1'b0;
            bat_resp_valid  = bat_lookup && (!hold_other || i >= 2);
            walk_resp_valid = walk_lookup;
            if (bat_lookup) s_bat = 1;
            if (walk_lookup) s_walk = 1;
            if (exc_req) begin
                s_exc = 1; s_vec = exc_vector; s_faddr = fault_addr;
                s_imiss = imiss_we; s_dmiss = dmiss_we; s_dar = dar_we;
                s_stat = stat_we; s_statv = stat_bits; s_tgpr = msr_tgpr_set;
            end
            if (imiss_we | dmiss_we | dar_we | stat_we | msr_tgpr_set) begin
                s_imiss |= imiss_we; s_dmiss |= dmiss_we; s_dar |= dar_we;
                s_stat |= stat_we; s_tgpr |= msr_tgpr_set;
            end
            if (done) begin
                s_done = 1; s_acc = res_access; s_pa = res_paddr;
                break;
            end
            @(negedge clk);
        end
        bat_resp_valid = 0; walk_resp_valid = 0; req_valid = 0;
        @(negedge clk);
        s_after_done = done | busy;
    endtask

    task automatic t_reset;
        check("R1 busy", busy, 0);
        check("R1 done", done, 0);
        check("R1 lookups", {bat_lookup, walk_lookup}, 0);
        check("R1 exc", exc_req, 0);
    endtask

    task automatic t_bypass;
        cfg_ireloc = 0; cfg_dreloc = 1;
        run_req(1, 0, 0, 32'h1234_5678, 1, 2'd2, 32'hAAAA_0000, 1, 2'd2, 32'hBBBB_0000, 0);
        check("R2 fetch bypass pa", s_pa, 32'h1234_5678);
        check("R2 fetch bypass acc", s_acc, 2);
        check("R2 fetch bypass no lookup", {s_bat, s_walk}, 0);
        cfg_ireloc = 1; cfg_dreloc = 0;
        run_req(0, 1, 0, 32'h0000_ABC0, 1, 2'd1, 32'hAAAA_0000, 1, 2'd2, 32'hBBBB_0000, 0);
        check("R2 data bypass pa", s_pa, 32'h0000_ABC0);
        check("R2 data bypass acc", s_acc, 2);
        check("R2 data bypass no lookup", {s_bat, s_walk}, 0);
        // the other enable is off but this access type relocates
        run_req(1, 0, 0, 32'h0000_1000, 1, 2'd1, 32'h7700_1000, 0, 2'd0, 0, 0);
        check("R2 fetch relocates with dreloc off", {s_bat, s_pa}, {1'b1, 32'h7700_1000});
        cfg_dreloc = 1;
    endtask

    task automatic t_bat_hit;
        run_req(0, 0, 0, 32'h4000_0010, 1, 2'd1, 32'h8000_0010, 1, 2'd2, 32'hCCCC_0010, 0);
        check("R3 bat ro pa", s_pa, 32'h8000_0010);
        check("R3 bat ro acc", s_acc, 1);
        check("R3 no walk", s_walk, 0);
        run_req(1, 0, 0, 32'h4000_0020, 1, 2'd2, 32'h9000_0020, 0, 2'd0, 0, 0);
        check("R3 bat rw acc/pa", {s_acc, s_pa}, {2'd2, 32'h9000_0020});
    endtask

    task automatic t_walk;
        run_req(0, 1, 0, 32'h5000_0044, 0, 2'd0, 0, 1, 2'd2, 32'h0123_0044, 0);
        check("R4 walk consulted", {s_bat, s_walk}, 2'b11);
        check("R4 walk pa", s_pa, 32'h0123_0044);
        check("R4 walk acc", s_acc, 2);
        check("R4 no exc", s_exc, 0);
    endtask

    task automatic t_noexc;
        cfg_swreload = 0;
        run_req(0, 1, 1, 32'h6000_0000, 0, 2'd0, 0, 0, 2'd0, 0, 0);
        check("R5 silent acc", s_acc, 0);
        check("R5 no side effects", {s_exc, s_imiss, s_dmiss, s_dar, s_stat, s_tgpr}, 0);
        check("R5 done", s_done, 1);
        cfg_swreload = 1;
        run_req(1, 0, 1, 32'h6000_0100, 1, 2'd0, 0, 0, 2'd0, 0, 0);
        check("R5 silent bat deny", {s_acc, s_exc, s_tgpr, s_dar}, 0);
        cfg_swreload = 0;
    endtask

    task automatic t_swreload;
        cfg_swreload = 1;
        run_req(1, 0, 0, 32'h7000_1000, 0, 2'd0, 0, 0, 2'd0, 0, 0);
        check("R6 fetch vec", s_vec, 8'h10);
        check("R6 fetch imiss", {s_imiss, s_dmiss, s_tgpr}, 3'b101);
        check("R6 fetch addr", s_faddr, 32'h7000_1000);
        run_req(0, 0, 0, 32'h7000_2000, 0, 2'd0, 0, 0, 2'd0, 0, 0);
        check("R6 load vec", s_vec, 8'h11);
        check("R6 load dmiss", {s_imiss, s_dmiss, s_tgpr, s_dar}, 4'b0110);
        run_req(0, 1, 0, 32'h7000_3000, 0, 2'd0, 0, 1, 2'd0, 0, 0);
        check("R6 store vec", s_vec, 8'h12);
        check("R6 store addr", s_faddr, 32'h7000_3000);
        check("R6 fail acc", s_acc, 0);
        cfg_swreload = 0;
    endtask

    task automatic t_storage;
        cfg_swreload = 0;
        run_req(0, 0, 0, 32'h8100_0000, 0, 2'd0, 0, 0, 2'd0, 0, 0);
        check("R7 load notfound vec", s_vec, 8'h03);
        check("R7 load notfound stat", {s_dar, s_stat, s_statv}, {2'b11, 3'b001});
        check("R7 dar addr", s_faddr, 32'h8100_0000);
        check("R7 no tgpr", {s_tgpr, s_imiss, s_dmiss}, 0);
        run_req(0, 1, 0, 32'h8200_0000, 0, 2'd0, 0, 1, 2'd0, 0, 0);
        check("R7 store prot stat", s_statv, 3'b110);
        run_req(0, 1, 0, 32'h8300_0000, 0, 2'd0, 0, 0, 2'd0, 0, 0);
        check("R7 store notfound stat", s_statv, 3'b101);
        run_req(1, 0, 0, 32'h8400_0000, 0, 2'd0, 0, 1, 2'd0, 0, 0);
        check("R8 fetch vec", s_vec, 8'h04);
        check("R8 fetch no regs", {s_dar, s_stat, s_imiss, s_dmiss, s_tgpr}, 0);
    endtask

    task automatic t_bat_deny;
        cfg_swreload = 1;
        run_req(0, 0, 0, 32'h9000_0000, 1, 2'd0, 32'h1, 1, 2'd2, 32'h2, 0);
        check("R9 deny no walk", s_walk, 0);
        check("R9 deny vec", s_vec, 8'h03);
        check("R9 deny stat", {s_dar, s_statv}, {1'b1, 3'b010});
        check("R9 deny no reload", {s_tgpr, s_dmiss}, 0);
        check("R9 deny acc", s_acc, 0);
        cfg_swreload = 0;
    endtask

    task automatic t_single;
        run_req(0, 0, 0, 32'hA000_0000, 1, 2'd2, 32'hA500_0000, 0, 2'd0, 0, 1);
        check("R10 busy request kept", s_pa, 32'hA500_0000);
        check("R10 done once then idle", s_after_done, 0);
        run_req(0, 0, 0, 32'hA000_1000, 1, 2'd1, 32'hA600_1000, 0, 2'd0, 0, 0);
        check("R10 next request served", {s_done, s_pa}, {1'b1, 32'hA600_1000});
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                t_reset();
                rst_n = 1'b1;
                @(negedge clk);
                t_reset();
                t_bypass();
                t_bat_hit();
                t_walk();
                t_noexc();
                t_swreload();
                t_storage();
                t_bat_deny();
                t_single();
            end
            begin
                repeat (20000) @(posedge clk);
                tests++; fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule